// File: doc/BRIEF.md
# Adaptive Pulse-and-Verify Programming Sequencer

This block programs a one-time-programmable byte memory. After a start request it selects the elevated programming supply and waits for it to settle. It then walks the address range from zero up to a configurable last address. At each location it fetches the target byte from a data source port and drives it with the address. It waits a settle interval and fires an active-low program strobe of fixed width. It then reads the location back once. A match moves it on to the next address. A mismatch repeats the settle and strobe at the same address, up to a fixed pulse budget. When the budget runs out the block reports a device failure at once.

When every location has been programmed, the sequencer selects the nominal supply and waits for it to settle. It then reads each location once more in address order. Any difference ends the run as a failure. A clean pass ends it as a success. Completion is flagged by a one-cycle done pulse. The pass and fail flags hold their value until the next start. The memory array and the supply generation lie outside the block. The supply appears only as a level-select output.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, done, pass and fail are 0, the strobe `mem_pgm_n` is 1, `mem_rd` is 0 and `vsel_prog` is 0.
- R2: A start seen in idle clears pass and fail and raises `vsel_prog` (1 = elevated supply) from the next cycle. The block then holds SETTLE_CYC cycles before any strobe activity, and programming starts at address 0.
- R3: Every strobe is preceded by SETTLE_CYC cycles with the same address on `mem_addr`, with `vsel_prog` high and `mem_pgm_n` high. The strobe then holds `mem_pgm_n` low for exactly 10×CLK_PER_US cycles with that address steady.
- R4: The cycle right after each strobe is a single read cycle (`mem_rd` = 1) at the same address. If `mem_rdata` equals `src_data` there, the next cycle begins the settle for the following address.
- R5: On a read-back mismatch the same address gets another settle and strobe. If MAX_PULSES (25) strobes at one address all fail to verify, the next cycle is the done cycle with fail = 1, and no further strobe is issued.
- R6: After the last address verifies, `vsel_prog` drops to 0 for SETTLE_CYC cycles. One read cycle per address then follows, from 0 to LAST_ADDR, with no strobe.
- R7: A mismatch in the final read pass ends the run with fail = 1 in the next cycle. If every byte matches, the run ends with pass = 1. Pass and fail are never both 1.
- R8: `done` is high for exactly one cycle, the cycle after the deciding read. Pass and fail keep their value after it until the next start.
- R9: A start request while a run is in progress has no effect on the strobe, read, supply or result outputs.
- R10: A target byte of 8'hFF, the erased value, verifies after its first strobe whatever the memory does with program pulses. Such an address takes exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a programming run (sampled in idle only) |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Device passed; held until next start |
| fail | output | 1 | Device failed; held until next start |
| src_data | input | 8 | Target byte for the address on `mem_addr` (combinational source) |
| mem_addr | output | ADDR_W | Memory address, also indexes the data source |
| mem_wdata | output | 8 | Byte driven to the memory data lines |
| mem_pgm_n | output | 1 | Active-low program strobe |
| mem_rd | output | 1 | Verify read enable; `mem_rdata` is sampled in this cycle |
| mem_rdata | input | 8 | Byte read back from the memory |
| vsel_prog | output | 1 | Supply select: 1 = elevated programming level, 0 = nominal |

## Verification
The bench builds the sequencer with a 3-bit address and a last address of 5. CLK_PER_US is 1, which gives 10-cycle strobes, and SETTLE_CYC is 3. Each full run therefore takes a few hundred cycles, while the pulse budget stays at its real value of 25. This makes the exact 25-pulse exhaustion boundary reachable: one byte verifies on its 25th pulse and another needs a 26th. A behavioural memory model applies a per-address number of pulses before a byte takes its data. It can also disturb one byte when the supply drops, so that the final pass sees a failure after programming verified cleanly.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SUP_UP,
    ST_PRE,
    ST_STROBE,
    ST_CHECK,
    ST_SUP_DN,
    ST_FVER,
    ST_FINISH
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/otp_seq_rst_sync.sv
module otp_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/otp_seq_timer.sv
module otp_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/otp_seq_addr_ctr.sv
module otp_seq_addr_ctr #(
  parameter int ADDR_W    = 18,
  parameter int LAST_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = clr | inc;
    addr_d  = clr ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == LAST_A);

endmodule

// File: rtl/otp_seq_retry_ctr.sv
module otp_seq_retry_ctr #(
  parameter int MAX_PULSES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);

  localparam int RTY_W = $clog2(MAX_PULSES + 1);
  localparam logic [RTY_W-1:0] LIMIT = RTY_W'(MAX_PULSES - 1);

  logic [RTY_W-1:0] cnt_q;
  logic [RTY_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // cnt_q holds the number of failed verifies so far at this address
  assign at_limit = (cnt_q == LIMIT);

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
  parameter int ADDR_W     = 18,
  parameter int LAST_ADDR  = 262143,
  parameter int CLK_PER_US = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic              fail,
  input  logic [7:0]        src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_pgm_n,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              vsel_prog
);
  import otp_seq_pkg::*;

  localparam int PULSE_CYC = 10 * CLK_PER_US;
  localparam int LONGEST   = max_int(PULSE_CYC, SETTLE_CYC);
  localparam int TMR_W     = (LONGEST > 2) ? $clog2(LONGEST) : 1;
  localparam logic [TMR_W-1:0] SET_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] PLS_LD = TMR_W'(PULSE_CYC - 1);

  logic       srst_n;
  seq_state_e state_q;
  seq_state_e state_d;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             addr_clr;
  logic             addr_inc;
  logic             addr_last;
  logic             rty_clr;
  logic             rty_inc;
  logic             rty_limit;
  logic             res_clr;
  logic             res_pass_set;
  logic             res_fail_set;
  logic             pass_q;
  logic             fail_q;
  logic             byte_match;

  otp_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  otp_seq_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  otp_seq_addr_ctr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (addr_clr),
    .inc     (addr_inc),
    .addr    (mem_addr),
    .at_last (addr_last)
  );

  otp_seq_retry_ctr #(.MAX_PULSES(MAX_PULSES)) u_rty (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (rty_clr),
    .inc      (rty_inc),
    .at_limit (rty_limit)
  );

  assign byte_match = (mem_rdata == src_data);

  // next-state and control decode
  always_comb begin
    state_d      = state_q;
    tmr_load     = 1'b0;
    tmr_val      = SET_LD;
    addr_clr     = 1'b0;
    addr_inc     = 1'b0;
    rty_clr      = 1'b0;
    rty_inc      = 1'b0;
    res_clr      = 1'b0;
    res_pass_set = 1'b0;
    res_fail_set = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SUP_UP;
          tmr_load = 1'b1;
          addr_clr = 1'b1;
          rty_clr  = 1'b1;
          res_clr  = 1'b1;
        end
      end
      ST_SUP_UP: begin
        if (tmr_zero) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
        end
      end
      ST_PRE: begin
        if (tmr_zero) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = PLS_LD;
        end
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (byte_match) begin
          rty_clr  = 1'b1;
          tmr_load = 1'b1;
          if (addr_last) begin
            state_d  = ST_SUP_DN;
            addr_clr = 1'b1;
          end else begin
            state_d  = ST_PRE;
            addr_inc = 1'b1;
          end
        end else if (rty_limit) begin
          state_d      = ST_FINISH;
          res_fail_set = 1'b1;
        end else begin
          state_d  = ST_PRE;
          rty_inc  = 1'b1;
          tmr_load = 1'b1;
        end
      end
      ST_SUP_DN: begin
        if (tmr_zero) begin
          state_d = ST_FVER;
        end
      end
      ST_FVER: begin
        if (!byte_match) begin
          state_d      = ST_FINISH;
          res_fail_set = 1'b1;
        end else if (addr_last) begin
          state_d      = ST_FINISH;
          res_pass_set = 1'b1;
        end else begin
          addr_inc = 1'b1;
        end
      end
      ST_FINISH: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (res_clr | res_pass_set | res_fail_set) begin
      pass_q <= res_pass_set;
      fail_q <= res_fail_set;
    end
  end

  assign done      = (state_q == ST_FINISH);
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign mem_wdata = src_data;
  assign mem_pgm_n = (state_q != ST_STROBE);
  assign mem_rd    = (state_q == ST_CHECK) || (state_q == ST_FVER);
  assign vsel_prog = (state_q == ST_SUP_UP) || (state_q == ST_PRE) ||
                     (state_q == ST_STROBE) || (state_q == ST_CHECK);

endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk #(
  parameter int ADDR_W    = 18,
  parameter int PULSE_CYC = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_pgm_n,
  input logic              mem_rd,
  input logic              vsel_prog
);

  localparam int CW = $clog2(PULSE_CYC + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!mem_pgm_n) begin
      if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assert_strobe_elevated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> vsel_prog);

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> (low_cnt == CW'(PULSE_CYC)));

  assert_addr_set_before_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pgm_n) |-> $stable(mem_addr));

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_pgm_n && $past(!mem_pgm_n)) |-> $stable(mem_addr));

  assert_read_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> (mem_rd && $stable(mem_addr)));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && !mem_pgm_n));

  assert_result_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));

endmodule

bind otp_prog_seq otp_seq_chk #(
  .ADDR_W    (ADDR_W),
  .PULSE_CYC (10 * CLK_PER_US)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .pass      (pass),
  .fail      (fail),
  .mem_addr  (mem_addr),
  .mem_pgm_n (mem_pgm_n),
  .mem_rd    (mem_rd),
  .vsel_prog (vsel_prog)
);

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;

  localparam int AW   = 3;
  localparam int LAST = 5;
  localparam int CPU  = 1;
  localparam int MAXP = 25;
  localparam int S    = 3;
  localparam int P    = 10 * CPU;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          done;
  logic          pass;
  logic          fail;
  logic [7:0]    src_data;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_pgm_n;
  logic          mem_rd;
  logic [7:0]    mem_rdata;
  logic          vsel_prog;

  int tests  = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural memory and data source
  logic [7:0] tgt   [0:7];
  logic [7:0] mem_m [0:7];
  int         need  [0:7];
  int         pcount[0:7];
  int         leak_addr;
  logic [7:0] leak_mask;

  otp_prog_seq #(
    .ADDR_W(AW), .LAST_ADDR(LAST), .CLK_PER_US(CPU),
    .MAX_PULSES(MAXP), .SETTLE_CYC(S)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
    .fail(fail), .src_data(src_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_pgm_n(mem_pgm_n), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .vsel_prog(vsel_prog)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign src_data  = tgt[mem_addr];
  assign mem_rdata = mem_m[mem_addr];

  // a pulse takes effect only once the byte has seen its required count
  always @(negedge mem_pgm_n) begin
    pcount[mem_addr] = pcount[mem_addr] + 1;
    if (pcount[mem_addr] >= need[mem_addr])
      mem_m[mem_addr] = mem_m[mem_addr] & mem_wdata;
  end

  // optional disturbance of one byte when the supply returns to nominal
  always @(negedge vsel_prog) begin
    if (leak_addr >= 0) mem_m[leak_addr] = mem_m[leak_addr] ^ leak_mask;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    tests++;
    errors++;
    $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
    summary();
  end

  // compare one cycle against the reference, then advance to next sample point
  task automatic cyc(input bit ev, input bit ep, input bit er, input int ea,
                     input bit ed, input bit eps, input bit ef, input string tag);
    bit bad;
    bad = (vsel_prog !== ev) || (mem_pgm_n !== ep) || (mem_rd !== er) ||
          (done !== ed) || (pass !== eps) || (fail !== ef);
    if ((!ep || er) && (mem_addr !== AW'(ea))) bad = 1;
    tests++;
    if (bad) begin
      errors++;
      $display("FAIL %s: got vsel=%b pgm_n=%b rd=%b addr=%0d done=%b pass=%b fail=%b; expected vsel=%b pgm_n=%b rd=%b addr=%0d done=%b pass=%b fail=%b",
               tag, vsel_prog, mem_pgm_n, mem_rd, mem_addr, done, pass, fail,
               ev, ep, er, ea, ed, eps, ef);
    end
    @(negedge clk);
  endtask

  task automatic reset_model();
    for (int i = 0; i < 8; i++) begin
      mem_m[i]  = 8'hFF;
      pcount[i] = 0;
      need[i]   = 1;
      tgt[i]    = 8'hFF;
    end
    leak_addr = -1;
    leak_mask = 8'h00;
  endtask

  function automatic bit verifies(input int a, input int k);
    return (tgt[a] == 8'hFF) || (k >= need[a]);
  endfunction

  // reference timeline for one run
  task automatic run_case();
    bit failed;
    failed = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (S) cyc(1, 1, 0, 0, 0, 0, 0, "R2");
    for (int a = 0; a <= LAST && !failed; a++) begin
      int k;
      bit ok;
      k = 0;
      ok = 0;
      while (!ok && !failed) begin
        repeat (S) cyc(1, 1, 0, a, 0, 0, 0, "R3");
        repeat (P) cyc(1, 0, 0, a, 0, 0, 0, "R3");
        cyc(1, 1, 1, a, 0, 0, 0, "R4");
        k++;
        if (verifies(a, k)) ok = 1;
        else if (k == MAXP) failed = 1;
      end
    end
    if (failed) begin
      cyc(0, 1, 0, 0, 1, 0, 1, "R5");
      cyc(0, 1, 0, 0, 0, 0, 1, "R8");
    end else begin
      repeat (S) cyc(0, 1, 0, 0, 0, 0, 0, "R6");
      for (int a = 0; a <= LAST && !failed; a++) begin
        cyc(0, 1, 1, a, 0, 0, 0, "R6");
        if (a == leak_addr && leak_mask != 8'h00) failed = 1;
      end
      if (failed) cyc(0, 1, 0, 0, 1, 0, 1, "R7");
      else        cyc(0, 1, 0, 0, 1, 1, 0, "R7");
      repeat (4) cyc(0, 1, 0, 0, 0, !failed, failed, "R8");
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    reset_model();
    repeat (3) @(negedge clk);
    cyc(0, 1, 0, 0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cyc(0, 1, 0, 0, 0, 0, 0, "R1");

    // case A: single pulse per byte; addr 3 is erased value needing many pulses
    reset_model();
    tgt[0] = 8'hA5; tgt[1] = 8'h00; tgt[2] = 8'h3C;
    tgt[3] = 8'hFF; need[3] = 9;    // R10: one strobe only
    tgt[4] = 8'h7E; tgt[5] = 8'h81;
    run_case();

    // case B: varied pulse needs, addr 4 verifies on exactly the 25th; start poked mid-run (R9)
    reset_model();
    tgt[0] = 8'h12; need[0] = 2;
    tgt[1] = 8'hEF; need[1] = 4;
    tgt[2] = 8'h55; need[2] = 1;
    tgt[3] = 8'hC3; need[3] = 3;
    tgt[4] = 8'h0F; need[4] = 25;
    tgt[5] = 8'hF0; need[5] = 2;
    fork
      run_case();
      begin
        repeat (60) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join

    // case C: addr 2 needs 26 pulses -> fail after the 25th (R5)
    reset_model();
    tgt[0] = 8'h01; tgt[1] = 8'h02;
    tgt[2] = 8'h04; need[2] = 26;
    tgt[3] = 8'h08;
    run_case();

    // case D: programming verifies, one byte disturbed before final pass (R7)
    reset_model();
    tgt[0] = 8'h11; tgt[1] = 8'h22; tgt[2] = 8'h33;
    tgt[3] = 8'h44; need[3] = 2; tgt[4] = 8'h55; tgt[5] = 8'h66;
    leak_addr = 4;
    leak_mask = 8'h80;
    run_case();

    // case E: back-to-back clean run after a failure clears the result (R2)
    reset_model();
    tgt[5] = 8'h00; need[5] = 5;
    run_case();

    summary();
  end

endmodule